// File: doc/BRIEF.md
# Two-Class Switch Allocator with Express Bypass

This block grants the output ports of one five-port mesh router to the input virtual channels that compete for them. Every input VC presents a valid flit, the output port it wants, a credit flag for its downstream buffer, a tail flag, and a one-bit urgency mark. On each output, marked (urgent) requests beat unmarked ones. Inside each class, a separate rotating pointer on each output shares the port fairly.

Switching is wormhole. When a non-tail flit is granted, its output stays reserved for that VC until the VC's tail flit is granted. An urgent winner that faces no rival on an unreserved output is also told to take the single-cycle express path. That path folds the buffer-write, route, VC-allocation and switch-allocation steps into one cycle ahead of traversal. Grants are combinational from the current inputs and registered state. The pointers and reservations update on the clock edge.

Top module: `prio_switch_alloc`

## Requirements
- R1: While reset is held, and in any cycle with no valid request, every grant bit and every express bit is 0. After reset each output has no reservation, and both of its class pointers point just before VC 0.
- R2: A grant on output o to VC i requires all of the following: req_vld[i] = 1, req_cred[i] = 1, and a port field req_port[i*3 +: 3] equal to o (0..4). A port value of 5 or above is never granted.
- R3: Each output's slice gnt[o*20 +: 20] is one-hot or zero, and no VC is granted more than one output in a cycle. The input VC index is i = port*4 + vc.
- R4: On an unreserved output, if any eligible request is marked urgent (req_hi = 1), the winner is an urgent request.
- R5: Within the winning class, the winner is the first eligible VC found by searching upward (with wrap) from the VC after that class's last winner on that output.
- R6: A grant to a flit with req_tail = 0 reserves the output for that VC. While the reservation holds, only that VC can be granted the output, whatever the mark of any rival. The grant of its tail flit releases it.
- R7: bypass[o] is 1 exactly when output o is unreserved, its winner is urgent, and that winner is the only eligible request for o.
- R8: An urgent winner that has an eligible rival, and any unmarked winner, gets its grant with bypass[o] = 0.
- R9: Urgent wins move only the urgent pointer and unmarked wins move only the unmarked pointer. Grants made under a reservation move neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 20 | Flit present at each input VC |
| req_hi | input | 20 | Urgency mark for each input VC |
| req_tail | input | 20 | Flit is the tail of its packet |
| req_cred | input | 20 | Downstream buffer has at least one credit |
| req_port | input | 60 | Requested output, 3 bits per VC |
| gnt | output | 100 | Grant matrix, 20 bits per output |
| bypass | output | 5 | Granted flit on this output takes the express path |

## Verification
The bench aims at a reservation that an urgent rival tries to break. A design that let priority override the wormhole hold would interleave two packets on one link. It also mixes urgent and unmarked traffic on a shared output. Pointers merged across classes would then skip or repeat unmarked VCs after an urgent win. Express grants are checked with and without a rival, because a design that ignored contention would send two flits into the traversal stage at once. Zero credits and out-of-range port values are also driven, since a missing credit check would overflow a downstream buffer.

// File: rtl/prio_switch_alloc.sv
module prio_switch_alloc #(
  parameter int NPORT = 5,
  parameter int NVC = 4,
  localparam int NIN = NPORT * NVC,
  localparam int IW = $clog2(NIN),
  localparam int PW = $clog2(NPORT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       req_vld,
  input  logic [NIN-1:0]       req_hi,
  input  logic [NIN-1:0]       req_tail,
  input  logic [NIN-1:0]       req_cred,
  input  logic [NIN*PW-1:0]    req_port,
  output logic [NPORT*NIN-1:0] gnt,
  output logic [NPORT-1:0]     bypass
);

  logic [NPORT-1:0] lock;
  logic [IW-1:0]    owner [NPORT];
  logic [IW-1:0]    ptr_hi [NPORT];
  logic [IW-1:0]    ptr_lo [NPORT];

  logic [NIN-1:0]   elig [NPORT];
  logic [IW-1:0]    win [NPORT];
  logic [NPORT-1:0] found, win_hi, sole;

  always_comb begin
    int idx;
    logic hi_any;
    gnt = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NIN; i++)
        elig[o][i] = rst_n && req_vld[i] && req_cred[i] &&
                     (req_port[i*PW +: PW] == PW'(o)) &&
                     (!lock[o] || owner[o] == IW'(i));
      hi_any = |(elig[o] & req_hi);
      found[o] = 1'b0;
      win[o] = '0;
      for (int k = 1; k <= NIN; k++) begin
        idx = int'(hi_any ? ptr_hi[o] : ptr_lo[o]) + k;
        if (idx >= NIN) idx = idx - NIN;
        if (!found[o] && elig[o][idx] && (!hi_any || req_hi[idx])) begin
          found[o] = 1'b1;
          win[o] = IW'(idx);
        end
      end
      win_hi[o] = found[o] && hi_any;
      sole[o] = $countones(elig[o]) == 1;
      for (int i = 0; i < NIN; i++)
        gnt[o*NIN + i] = found[o] && (win[o] == IW'(i));
    end
  end

  assign bypass = found & win_hi & sole & ~lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock <= '0;
      for (int o = 0; o < NPORT; o++) begin
        owner[o]  <= '0;
        ptr_hi[o] <= IW'(NIN - 1);
        ptr_lo[o] <= IW'(NIN - 1);
      end
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (found[o]) begin
          if (!lock[o]) begin
            if (win_hi[o]) ptr_hi[o] <= win[o];
            else           ptr_lo[o] <= win[o];
          end
          lock[o]  <= !req_tail[win[o]];
          owner[o] <= win[o];
        end
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port_chk
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[g*NIN +: NIN])); // R3
    AST_WORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt[g*NIN +: NIN] != '0) && ((gnt[g*NIN +: NIN] & req_tail) == '0))
      |=> ((gnt[g*NIN +: NIN] & ~$past(gnt[g*NIN +: NIN])) == '0)); // R6
    AST_BYPASS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      bypass[g] |-> ((gnt[g*NIN +: NIN] & req_hi) != '0)); // R7
    for (genvar h = 0; h < NIN; h++) begin : g_vc_chk
      AST_GNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[g*NIN + h] |-> (req_vld[h] && req_cred[h] &&
                            req_port[h*PW +: PW] == PW'(g))); // R2
    end
  end

endmodule

// File: tb/prio_switch_alloc_tb.sv
`timescale 1ns/1ps
module prio_switch_alloc_tb_top;
  localparam int NP = 5, NV = 4, NIN = NP * NV, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN-1:0] v = '0, h = '0, t = '0, c = '0;
  logic [NIN*PW-1:0] pt = '0;
  logic [NP*NIN-1:0] gnt;
  logic [NP-1:0] bypass;

  int tests = 0, fails = 0;
  int m_lk[NP], m_own[NP], m_phi[NP], m_plo[NP];
  int e_win[NP], e_hi[NP], e_found[NP];
  logic [NP*NIN-1:0] e_gnt;
  logic [NP-1:0] e_byp;

  always #2.5 clk = ~clk;

  prio_switch_alloc dut_i (.clk(clk), .rst_n(rst_n), .req_vld(v), .req_hi(h),
    .req_tail(t), .req_cred(c), .req_port(pt), .gnt(gnt), .bypass(bypass));

  function automatic void model_reset();
    for (int o = 0; o < NP; o++) begin
      m_lk[o] = 0; m_own[o] = 0; m_phi[o] = NIN - 1; m_plo[o] = NIN - 1;
    end
  endfunction

  function automatic void model_eval();
    e_gnt = '0; e_byp = '0;
    for (int o = 0; o < NP; o++) begin
      int all[$];
      int pool[$];
      int best, bestd;
      for (int i = 0; i < NIN; i++)
        if (v[i] && c[i] && int'(pt[i*PW +: PW]) == o && (!m_lk[o] || m_own[o] == i))
          all.push_back(i);
      foreach (all[j]) if (h[all[j]]) pool.push_back(all[j]);
      e_hi[o] = pool.size() > 0;
      if (!e_hi[o]) pool = all;
      e_found[o] = pool.size() > 0;
      best = 0; bestd = NIN + 1;
      foreach (pool[j]) begin
        int d;
        d = (pool[j] - (e_hi[o] ? m_phi[o] : m_plo[o]) - 1 + 2 * NIN) % NIN;
        if (d < bestd) begin bestd = d; best = pool[j]; end
      end
      e_win[o] = best;
      if (e_found[o]) begin
        e_gnt[o*NIN + best] = 1'b1;
        e_byp[o] = e_hi[o] && !m_lk[o] && all.size() == 1;
      end
    end
  endfunction

  function automatic void model_commit();
    for (int o = 0; o < NP; o++)
      if (e_found[o]) begin
        if (!m_lk[o]) begin
          if (e_hi[o]) m_phi[o] = e_win[o]; else m_plo[o] = e_win[o];
        end
        m_lk[o] = !t[e_win[o]];
        m_own[o] = e_win[o];
      end
  endfunction

  task automatic check(string tag, logic [NP*NIN-1:0] ag, logic [NP*NIN-1:0] eg,
                       logic [NP-1:0] ab, logic [NP-1:0] eb);
    tests++;
    if (ag !== eg) begin
      fails++; $display("FAIL %s gnt actual=%h expected=%h", tag, ag, eg);
    end
    tests++;
    if (ab !== eb) begin
      fails++; $display("FAIL %s bypass actual=%b expected=%b", tag, ab, eb);
    end
  endtask

  task automatic step(string tag);
    #1;
    model_eval();
    check(tag, gnt, e_gnt, bypass, e_byp);
    for (int i = 0; i < NIN; i++) begin
      int n = 0;
      for (int o = 0; o < NP; o++) n += int'(gnt[o*NIN + i]);
      tests++;
      if (n > 1) begin
        fails++; $display("FAIL R3 vc %0d grants actual=%0d expected<=1", i, n);
      end
    end
    model_commit();
    @(posedge clk); #1;
  endtask

  task automatic clr();
    v = '0; h = '0; t = '0; c = '0; pt = '0;
  endtask

  task automatic put(int i, int port, bit hi, bit tail, bit cr);
    v[i] = 1'b1; h[i] = hi; t[i] = tail; c[i] = cr; pt[i*PW +: PW] = PW'(port);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    put(2, 1, 1, 1, 1);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", gnt, '0, bypass, '0);
    clr();
    rst_n = 1'b1;
    @(posedge clk); #1;
    step("R1 idle");
    put(7, 2, 0, 1, 1);
    step("R8 lone unmarked");
    clr(); put(4, 3, 0, 1, 0); put(5, 1, 0, 1, 1); pt[5*PW +: PW] = 3'd6;
    step("R2 no credit / bad port");
    clr(); put(9, 4, 1, 1, 1);
    step("R7 lone urgent bypass");
    clr(); put(1, 0, 0, 1, 1); put(14, 0, 1, 1, 1);
    step("R4 urgent beats unmarked");
    clr(); put(3, 1, 0, 1, 1); put(8, 1, 0, 1, 1); put(17, 1, 0, 1, 1);
    repeat (4) step("R5 rotation");
    put(11, 1, 1, 1, 1);
    step("R9 urgent win");
    v[11] = 1'b0;
    repeat (3) step("R9 unmarked pointer kept");
    clr(); put(3, 0, 0, 0, 1);
    step("R6 head reserves");
    put(10, 0, 1, 1, 1);
    step("R6 urgent rival blocked");
    c[3] = 1'b0;
    step("R6 owner stalled");
    c[3] = 1'b1; t[3] = 1'b1;
    step("R6 tail releases");
    v[3] = 1'b0;
    step("R6 rival served");
    clr();
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NIN; i++) begin
        v[i] = ($urandom_range(0, 3) != 0);
        h[i] = ($urandom_range(0, 3) == 0);
        t[i] = ($urandom_range(0, 2) == 0);
        c[i] = ($urandom_range(0, 5) != 0);
        pt[i*PW +: PW] = PW'($urandom_range(0, 5));
      end
      step("R3 random mix");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule